// File: doc/BRIEF.md
# USB VBUS Power Switch Controller

This block controls an external supply that powers the USB VBUS rail. It drives that supply's enable pin and watches the supply's power-fault pin. Software reaches it through four byte-wide registers. With them it claims the two pins from general-purpose I/O, sets the active level of each pin, chooses what a power fault does, and requests bus power.

A fault can switch the supply off in hardware, raise an interrupt, or do both. A separate attach-sense input reports device insertion and removal. A removal while bus power is being supplied is also reported as a disconnect. The fault and attach-sense inputs pass through two-flop synchronizers. A fault counts only after it has stayed active longer than a programmed number of cycles.

Register map, selected by `reg_addr`:

- 0: control.
  - bit0 `own`: the controller drives the pins.
  - bit1 `en_hi`: the enable pin is active high.
  - bit2 `flt_hi`: the fault pin is active high.
  - bit3 `auto_off`: a qualified fault cuts power.
  - bit4 `flt_irq`: a fault may raise the interrupt.
  - bit5 `host`: host role.
  - bit6 `power`: writes a power request; reads back the actual power state.
- 1: flags, write 1 to clear.
  - bit0: fault.
  - bit1: insertion.
  - bit2: removal.
  - bit3: disconnect.
- 2: interrupt mask, bits 3:0, aligned with the flags.
- 3: fault filter length.

Top module: `vbus_pwr_ctl`

## Requirements
- R1: After reset the enable pin is low (the inactive level of the default active-high polarity), `vbus_en_oe` is 0, all flags and `irq` are 0, control reads 0x02 and the filter reads 4.
- R2: While control bit0 is 0, `vbus_en_oe` is 0 and the fault pin is ignored: it sets no flag and cuts no power.
- R3: The enable pin carries the enable state at the level chosen by control bit1 (1 = high when enabled). It comes from a register, so a control write shows on the pin one clock after the write edge.
- R4: The fault pin is active high when control bit2 is 1 and active low when it is 0. After the two-flop synchronizer, a fault qualifies only once it has been active for more cycles than the filter value (address 3). Shorter pulses have no effect.
- R5: With control bit3 set, a qualified fault clears the power state (control bit6 reads 0) and deasserts the enable pin without software action.
- R6: A power-request write is ignored while fault flag bit0 is set. Power returns only after software clears the flag and writes bit6 = 1 again.
- R7: The onset of a qualified fault sets flag bit0. That flag drives `irq` only when control bit4 and mask bit0 are both 1. Without bit3, the power stays on.
- R8: The enable is active only when own = 1, host = 1 and the power state is 1. With host = 0 the pin stays at its inactive level whatever the request.
- R9: A rising synchronized attach-sense sets flag bit1 and a falling one sets flag bit2. A fall while the enable is active also sets flag bit3.
- R10: Flags are sticky. Writing 1 to a flag bit clears only that bit. A set in the same cycle as a clear wins.
- R11: `irq` is the OR of the flags ANDed with the mask (address 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| vbus_flt_pin | input | 1 | Power-fault pin from the supply (asynchronous) |
| vbus_sense_pin | input | 1 | Attach-sense input (asynchronous) |
| vbus_en_o | output | 1 | Supply enable pin level |
| vbus_en_oe | output | 1 | Enable pin output-enable (1 = controller drives) |
| irq | output | 1 | Combined interrupt |

## Verification
The in-line assertions check on every cycle:
- hardware cut-off after a qualified fault;
- the power lockout while the fault flag stands;
- release of the pin when not owned;
- the inactive enable level in device role;
- the fault filter needing a prior active cycle;
- the sticky flag behaviour.

Only the bench scenarios can show the rest:
- that short fault pulses are filtered;
- that each polarity setting maps the right pin level;
- the one-cycle latency of a control write;
- that insertion, removal and disconnect are told apart;
- how the mask and the fault-interrupt enable combine on `irq`.

// File: rtl/vbus_pkg.sv
package vbus_pkg;
  localparam int NFLAG = 4;
  localparam int F_FAULT = 0;
  localparam int F_INS   = 1;
  localparam int F_REM   = 2;
  localparam int F_DISC  = 3;

  typedef struct packed {
    logic power;
    logic host;
    logic flt_irq;
    logic auto_off;
    logic flt_hi;
    logic en_hi;
    logic own;
  } ctrl_t;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_FLAG = 2'd1,
    A_MASK = 2'd2,
    A_FILT = 2'd3
  } addr_e;

  // pin level <-> logical state: equal when polarity is active high
  function automatic logic pol_map(input logic lvl, input logic act_hi);
    return lvl ~^ act_hi;
  endfunction

  function automatic logic irq_any(input logic [NFLAG-1:0] flags,
                                   input logic [NFLAG-1:0] mask,
                                   input logic flt_en);
    logic [NFLAG-1:0] g;
    g = flags & mask;
    g[F_FAULT] = g[F_FAULT] & flt_en;
    return |g;
  endfunction
endpackage

// File: rtl/vbus_sync.sv
module vbus_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st[0] <= '0;
          else        st[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st[s] <= '0;
          else        st[s] <= st[s-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/vbus_fault_filt.sv
module vbus_fault_filt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  logic [CW-1:0] limit,
  output logic          qual
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cnt <= '0;
    else if (!act)       cnt <= '0;
    else if (cnt < limit) cnt <= cnt + 1'b1;

  assign qual = act && (cnt >= limit);

  // R4: with a nonzero filter, a qualified fault was already active last cycle
  a_r4_filter_history: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && limit != '0) |-> $past(act));
endmodule

// File: rtl/vbus_irq_flags.sv
module vbus_irq_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[i] && !clr[i]) |=> flags[i]);
      a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set[i] |=> flags[i]);
    end
  endgenerate
endmodule

// File: rtl/vbus_pwr_ctl.sv
module vbus_pwr_ctl
  import vbus_pkg::*;
#(
  parameter int FW       = 8,
  parameter int FILT_RST = 4,
  parameter int SYNC_STG = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       vbus_flt_pin,
  input  logic       vbus_sense_pin,
  output logic       vbus_en_o,
  output logic       vbus_en_oe,
  output logic       irq
);
  localparam logic [FW-1:0] FILT_INIT = FW'(FILT_RST);

  ctrl_t            ctrl;
  logic [NFLAG-1:0] mask;
  logic [FW-1:0]    filt;
  logic [NFLAG-1:0] flags;
  logic [1:0]       pins_s;
  logic             flt_act, flt_qual, flt_qual_q, fault_onset, trip;
  logic             sense_q, ins_evt, rem_evt, disc_evt;
  logic             en_active;
  logic             wr_ctrl, wr_flag, wr_mask, wr_filt;
  logic [NFLAG-1:0] flag_set, flag_clr;

  assign wr_ctrl = reg_we && (addr_e'(reg_addr) == A_CTRL);
  assign wr_flag = reg_we && (addr_e'(reg_addr) == A_FLAG);
  assign wr_mask = reg_we && (addr_e'(reg_addr) == A_MASK);
  assign wr_filt = reg_we && (addr_e'(reg_addr) == A_FILT);

  vbus_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({vbus_sense_pin, vbus_flt_pin}), .q(pins_s));

  assign flt_act = ctrl.own && pol_map(pins_s[0], ctrl.flt_hi);

  vbus_fault_filt #(.CW(FW)) u_filt (
    .clk(clk), .rst_n(rst_n), .act(flt_act), .limit(filt), .qual(flt_qual));

  assign fault_onset = flt_qual && !flt_qual_q;
  assign trip        = flt_qual && ctrl.auto_off;
  assign en_active   = ctrl.own && ctrl.host && ctrl.power;
  assign ins_evt     = pins_s[1] && !sense_q;
  assign rem_evt     = !pins_s[1] && sense_q;
  assign disc_evt    = rem_evt && en_active;

  // control register; power bit holds the actual power state
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '{power: 1'b0, host: 1'b0, flt_irq: 1'b0, auto_off: 1'b0,
                flt_hi: 1'b0, en_hi: 1'b1, own: 1'b0};
    end else begin
      if (wr_ctrl) begin
        ctrl.own      <= reg_wdata[0];
        ctrl.en_hi    <= reg_wdata[1];
        ctrl.flt_hi   <= reg_wdata[2];
        ctrl.auto_off <= reg_wdata[3];
        ctrl.flt_irq  <= reg_wdata[4];
        ctrl.host     <= reg_wdata[5];
      end
      if (trip)         ctrl.power <= 1'b0;
      else if (wr_ctrl) ctrl.power <= reg_wdata[6] && !flags[F_FAULT];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask <= '0;
      filt <= FILT_INIT;
    end else begin
      if (wr_mask) mask <= reg_wdata[NFLAG-1:0];
      if (wr_filt) filt <= reg_wdata[FW-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt_qual_q <= 1'b0;
      sense_q    <= 1'b0;
    end else begin
      flt_qual_q <= flt_qual;
      sense_q    <= pins_s[1];
    end

  // registered pin drive: no glitch on polarity change
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vbus_en_o  <= 1'b0;
      vbus_en_oe <= 1'b0;
    end else begin
      vbus_en_o  <= pol_map(en_active, ctrl.en_hi);
      vbus_en_oe <= ctrl.own;
    end

  always_comb begin
    flag_set          = '0;
    flag_set[F_FAULT] = fault_onset;
    flag_set[F_INS]   = ins_evt;
    flag_set[F_REM]   = rem_evt;
    flag_set[F_DISC]  = disc_evt;
  end
  assign flag_clr = wr_flag ? reg_wdata[NFLAG-1:0] : '0;

  vbus_irq_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .flags(flags));

  assign irq = irq_any(flags, mask, ctrl.flt_irq);

  always_comb
    case (addr_e'(reg_addr))
      A_CTRL:  reg_rdata = {1'b0, ctrl};
      A_FLAG:  reg_rdata = {{(8-NFLAG){1'b0}}, flags};
      A_MASK:  reg_rdata = {{(8-NFLAG){1'b0}}, mask};
      default: reg_rdata = 8'(filt);
    endcase

  a_r2_release_pin: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.own |=> !vbus_en_oe);
  a_r5_auto_off: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_qual && ctrl.auto_off) |=> !ctrl.power);
  a_r6_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[F_FAULT] && !ctrl.power) |=> !ctrl.power);
  a_r8_device_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.host |=> (vbus_en_o == !$past(ctrl.en_hi)));
  a_r2_no_fault_unowned: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.own |-> !flt_qual);
endmodule

// File: tb/vbus_pwr_ctl_test.sv
module vbus_pwr_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       flt_pin = 1'b1;
  logic       sense_pin = 1'b0;
  logic       en_o, en_oe, irq;
  int         n_run = 0, n_fail = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  vbus_pwr_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vbus_flt_pin(flt_pin),
    .vbus_sense_pin(sense_pin), .vbus_en_o(en_o), .vbus_en_oe(en_oe), .irq(irq));

  // {ctrl byte, expected enable level, expected output-enable}
  localparam logic [9:0] VEC [0:7] = '{
    10'h00D, 10'h18F, 10'h185, 10'h107, 10'h10D, 10'h188, 10'h182, 10'h08D};

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    // R1 reset state
    chk("R1 en", {7'd0, en_o}, 8'd0);
    chk("R1 oe", {7'd0, en_oe}, 8'd0);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    rst_n = 1'b1;
    cyc(2);
    rd(2'd0, rv); chk("R1 ctrl", rv, 8'h02);
    rd(2'd1, rv); chk("R1 flags", rv, 8'h00);
    rd(2'd3, rv); chk("R1 filt", rv, 8'h04);

    // R3 R8 table of polarity / role / ownership
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, VEC[i][9:2]);
      cyc(1);
      chk($sformatf("R3 R8 vec%0d en", i), {7'd0, en_o}, {7'd0, VEC[i][1]});
      chk($sformatf("R2 vec%0d oe", i), {7'd0, en_oe}, {7'd0, VEC[i][0]});
    end

    // R3 one-cycle latency: power on, active high, then flip polarity
    wr(2'd0, 8'h63); cyc(1);
    wr(2'd0, 8'h61);
    chk("R3 old level before edge", {7'd0, en_o}, 8'd1);
    cyc(1);
    chk("R3 new level after edge", {7'd0, en_o}, 8'd0);

    // R4 filter + R5 auto-off: own, active-high enable, active-low fault
    wr(2'd0, 8'h6B); cyc(1);
    chk("R5 powered", {7'd0, en_o}, 8'd1);
    flt_pin = 1'b0; cyc(3); flt_pin = 1'b1; cyc(6);
    rd(2'd1, rv); chk("R4 short pulse ignored", rv, 8'h00);
    chk("R4 short pulse power kept", {7'd0, en_o}, 8'd1);
    flt_pin = 1'b0; cyc(12); flt_pin = 1'b1; cyc(4);
    rd(2'd1, rv); chk("R7 fault flag", rv, 8'h01);
    rd(2'd0, rv); chk("R5 power cleared", rv, 8'h2B);
    chk("R5 en off", {7'd0, en_o}, 8'd0);
    chk("R7 irq gated off", {7'd0, irq}, 8'd0);

    // R6 lockout
    wr(2'd0, 8'h6B); cyc(1);
    rd(2'd0, rv); chk("R6 request ignored", rv, 8'h2B);
    wr(2'd1, 8'h01);
    rd(2'd1, rv); chk("R10 fault cleared", rv, 8'h00);
    wr(2'd0, 8'h6B); cyc(1);
    chk("R6 power returns", {7'd0, en_o}, 8'd1);

    // R7 interrupt only, no auto-off
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h73);
    flt_pin = 1'b0; cyc(12); flt_pin = 1'b1; cyc(4);
    chk("R7 irq raised", {7'd0, irq}, 8'd1);
    chk("R7 power kept", {7'd0, en_o}, 8'd1);
    wr(2'd1, 8'h01); cyc(1);
    chk("R11 irq after clear", {7'd0, irq}, 8'd0);

    // R4 active-high fault: pin high now counts as fault
    wr(2'd0, 8'h77); cyc(12);
    rd(2'd1, rv); chk("R4 high-active fault", rv, 8'h01);
    flt_pin = 1'b0; cyc(4);
    wr(2'd1, 8'h01); cyc(12);
    rd(2'd1, rv); chk("R4 low idle under high polarity", rv, 8'h00);

    // R2 not owned: fault pin ignored
    flt_pin = 1'b1;
    wr(2'd0, 8'h76); cyc(12);
    rd(2'd1, rv); chk("R2 fault ignored unowned", rv, 8'h00);
    chk("R2 oe low", {7'd0, en_oe}, 8'd0);

    // R9 insertion / removal / disconnect
    wr(2'd0, 8'h63); wr(2'd2, 8'h0E); cyc(1);
    sense_pin = 1'b1; cyc(5);
    rd(2'd1, rv); chk("R9 insertion", rv, 8'h02);
    chk("R11 irq insertion", {7'd0, irq}, 8'd1);
    wr(2'd1, 8'h02);
    sense_pin = 1'b0; cyc(5);
    rd(2'd1, rv); chk("R9 removal with disconnect", rv, 8'h0C);
    wr(2'd1, 8'h04);
    rd(2'd1, rv); chk("R10 partial clear", rv, 8'h08);
    wr(2'd1, 8'h08);
    wr(2'd0, 8'h23);
    sense_pin = 1'b1; cyc(5); sense_pin = 1'b0; cyc(5);
    rd(2'd1, rv); chk("R9 removal without session", rv, 8'h06);
    wr(2'd2, 8'h00); cyc(1);
    chk("R11 masked irq", {7'd0, irq}, 8'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule